// File: doc/BRIEF.md
# Two-Way Tag Array with Parallel Victim Buffer

This block tracks which block addresses are resident in a small first-level data cache. The cache is two-way set-associative with four block slots in total. Beside it sits a fully associative victim buffer that is searched in the same cycle. Only tags, valid bits and recency state are stored; no data is held. A requester presents a block address. The block answers with a hit or miss flag and a nominal latency class: 1 cycle when either structure holds the block, `MISS_LAT` cycles when the next level must supply it.

Blocks leave the main array only by eviction, and each evicted block goes into the victim buffer. A victim-buffer hit swaps the block back into its set, so no block is ever held twice. A miss raises a request to the next level and waits for its acknowledge before the fill. Thanks to the buffer, a cyclic working set slightly larger than the main array still hits on every access.

The controller has two states. `ST_LOOKUP` accepts a request and resolves hits in the same cycle. `ST_MISS_WAIT` holds the next-level request until the acknowledge. The transitions are:
- `ST_LOOKUP` to `ST_MISS_WAIT`: an accepted request misses in both structures.
- `ST_MISS_WAIT` to `ST_LOOKUP`: the acknowledge arrives, the fill is done and the response is issued.
- Both states hold otherwise.

Top module: `l1vc_top`

## Requirements
- R1: A synchronous reset sets `req_ready`=1, `resp_valid`=0 and `mem_req`=0, and empties both structures, so the first access to any address afterwards misses.
- R2: A request that hits in the main array gives `resp_valid`=1, `resp_hit`=1 and `resp_lat`=1 in the cycle after the clock edge that accepted it, with no next-level request.
- R3: A request that misses in both structures raises `mem_req` with `mem_addr` equal to the request in the cycle after acceptance. `mem_req` and `mem_addr` hold until `mem_ack` is sampled high. The cycle after that edge gives `resp_valid`=1, `resp_hit`=0 and `resp_lat`=`MISS_LAT`.
- R4: Set index is address bit 0 (two sets, two ways each). A miss fills the least recently used way of its set, and every hit or fill makes the accessed way most recently used.
- R5: A victim-buffer hit answers like a main-array hit (`resp_hit`=1, `resp_lat`=1, no `mem_req`). The block moves into the LRU way of its set, and the block displaced from that way takes the freed buffer entry. A block is never in both structures.
- R6: Each block evicted from the main array enters the victim buffer as its most recent entry. When the buffer is full, the entry that was least recently inserted or refreshed is overwritten.
- R7: With the default 3-entry buffer, a cyclic loop over 5, 6 or 7 distinct consecutive blocks hits on every access in steady state. A loop over 8 or 9 blocks misses on every access.
- R8: There is no prefetch: after a miss on address X has been filled, an access to X+1 still misses.
- R9: While a miss is outstanding, `req_ready`=0 and `req_valid` is ignored: no response is issued for it and nothing is filled for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Requested block address |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_hit | output | 1 | 1 = hit in main array or victim buffer |
| resp_lat | output | LAT_W | Nominal latency class: 1 or MISS_LAT |
| mem_req | output | 1 | Next-level fetch request, held until acknowledged |
| mem_addr | output | ADDR_W | Address of the block being fetched |
| mem_ack | input | 1 | Next level has supplied the block |

## Verification
Hits in either structure are answered in the cycle after the accepting edge. A miss raises `mem_req` in that same cycle. The miss response appears one cycle after the edge on which `mem_ack` is sampled. The bench drives inputs on falling edges and reads outputs on the next falling edge, counting the falling edges from acceptance to response. A hit is only accepted when exactly one edge separates request and response. The acknowledge model counts `mem_req` cycles on the same falling edges, so the miss response time is known in advance.

// File: rtl/l1vc_pkg.sv
package l1vc_pkg;

    // controller states
    typedef enum logic [0:0] {
        ST_LOOKUP    = 1'b0,
        ST_MISS_WAIT = 1'b1
    } l1vc_state_e;

    // victim buffer operations
    typedef enum logic [1:0] {
        VB_IDLE = 2'd0,
        VB_SWAP = 2'd1,
        VB_PUSH = 2'd2
    } vb_op_e;

endpackage

// File: rtl/l1vc_sets.sv
// Two-way set-associative tag store with one LRU bit per set.
module l1vc_sets #(
    parameter int ADDR_W   = 16,
    parameter int NUM_SETS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_en,
    input  logic              upd_way,
    input  logic              upd_wr,
    output logic              hit,
    output logic              hit_way,
    output logic              lru_way,
    output logic              vic_valid,
    output logic [ADDR_W-1:0] vic_addr
);
    localparam int SET_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAYS  = 2;

    logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
    logic             valid_q [NUM_SETS][WAYS];
    logic             lru_q   [NUM_SETS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  way_match;

    assign set_idx = lk_addr[SET_W-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_match[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == lk_tag);
    end

    assign hit       = |way_match;
    assign hit_way   = way_match[1];
    assign lru_way   = lru_q[set_idx];
    assign vic_valid = valid_q[set_idx][lru_q[set_idx]];
    assign vic_addr  = {tag_q[set_idx][lru_q[set_idx]], set_idx};

    // valid bits and recency: reset to empty, way 0 least recent
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                end
            end
        end else if (upd_en) begin
            lru_q[set_idx] <= ~upd_way;
            if (upd_wr) begin
                valid_q[set_idx][upd_way] <= 1'b1;
            end
        end
    end

    // tags need no reset: qualified by valid
    always_ff @(posedge clk) begin
        if (upd_en && upd_wr) begin
            tag_q[set_idx][upd_way] <= lk_tag;
        end
    end

endmodule

// File: rtl/l1vc_vbuf.sv
// Fully associative victim buffer with an age ordering (0 = newest).
module l1vc_vbuf import l1vc_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int VB_N   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         lk_addr,
    input  vb_op_e                    op,
    input  logic [$clog2(VB_N)-1:0]   op_idx,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    output logic                      hit,
    output logic [$clog2(VB_N)-1:0]   hit_idx
);
    localparam int IDX_W = $clog2(VB_N);
    localparam logic [IDX_W-1:0] AGE_OLD = IDX_W'(VB_N - 1);

    logic              valid_q [VB_N];
    logic [ADDR_W-1:0] addr_q  [VB_N];
    logic [IDX_W-1:0]  age_q   [VB_N];

    logic              valid_d [VB_N];
    logic [ADDR_W-1:0] addr_d  [VB_N];
    logic [IDX_W-1:0]  age_d   [VB_N];

    logic [VB_N-1:0]   ent_match;
    logic [IDX_W-1:0]  push_slot;
    logic [IDX_W-1:0]  slot;
    logic              found_free;

    for (genvar i = 0; i < VB_N; i++) begin : g_ent
        assign ent_match[i] = valid_q[i] && (addr_q[i] == lk_addr);
    end

    assign hit = |ent_match;

    always_comb begin
        hit_idx = '0;
        for (int i = VB_N - 1; i >= 0; i--) begin
            if (ent_match[i]) hit_idx = IDX_W'(i);
        end
    end

    // push target: lowest free entry, else the oldest one
    always_comb begin
        push_slot  = '0;
        found_free = 1'b0;
        for (int i = 0; i < VB_N; i++) begin
            if (!valid_q[i] && !found_free) begin
                push_slot  = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < VB_N; i++) begin
                if (age_q[i] == AGE_OLD) push_slot = IDX_W'(i);
            end
        end
    end

    assign slot = (op == VB_SWAP) ? op_idx : push_slot;

    always_comb begin
        for (int i = 0; i < VB_N; i++) begin
            valid_d[i] = valid_q[i];
            addr_d[i]  = addr_q[i];
            age_d[i]   = age_q[i];
        end
        if ((op == VB_SWAP) || ((op == VB_PUSH) && wr_valid)) begin
            if (wr_valid) begin
                // insert: younger entries age by one, slot becomes newest
                valid_d[slot] = 1'b1;
                addr_d[slot]  = wr_addr;
                for (int i = 0; i < VB_N; i++) begin
                    if (age_q[i] < age_q[slot]) age_d[i] = age_q[i] + 1'b1;
                end
                age_d[slot] = '0;
            end else begin
                // removal: older entries move up, slot becomes oldest
                valid_d[slot] = 1'b0;
                for (int i = 0; i < VB_N; i++) begin
                    if (age_q[i] > age_q[slot]) age_d[i] = age_q[i] - 1'b1;
                end
                age_d[slot] = AGE_OLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VB_N; i++) begin
                valid_q[i] <= 1'b0;
                age_q[i]   <= IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < VB_N; i++) begin
                valid_q[i] <= valid_d[i];
                age_q[i]   <= age_d[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < VB_N; i++) begin
            addr_q[i] <= addr_d[i];
        end
    end

endmodule

// File: rtl/l1vc_ctrl.sv
// Request controller: lookup, miss handshake, array update commands.
module l1vc_ctrl import l1vc_pkg::*; #(
    parameter int ADDR_W   = 16,
    parameter int MISS_LAT = 20,
    parameter int LAT_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mem_ack,
    input  logic              main_hit,
    input  logic              main_hit_way,
    input  logic              main_lru_way,
    input  logic              vb_hit,
    output logic              req_ready,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LAT_W-1:0]  resp_lat,
    output logic              set_upd_en,
    output logic              set_upd_way,
    output logic              set_upd_wr,
    output vb_op_e            vb_op
);
    l1vc_state_e       state_q, state_d;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              accept;
    logic              any_hit;
    logic              fill_now;

    assign accept   = req_valid && (state_q == ST_LOOKUP);
    assign any_hit  = main_hit || vb_hit;
    assign fill_now = (state_q == ST_MISS_WAIT) && mem_ack;
    assign lk_addr  = (state_q == ST_LOOKUP) ? req_addr : miss_addr_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOOKUP;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:    if (accept && !any_hit) state_d = ST_MISS_WAIT;
            ST_MISS_WAIT: if (mem_ack)            state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (accept) miss_addr_q <= req_addr;
    end

    // array update commands
    always_comb begin
        set_upd_en  = 1'b0;
        set_upd_way = main_lru_way;
        set_upd_wr  = 1'b0;
        vb_op       = VB_IDLE;
        unique case (state_q)
            ST_LOOKUP: begin
                if (accept && main_hit) begin
                    set_upd_en  = 1'b1;
                    set_upd_way = main_hit_way;
                end else if (accept && vb_hit) begin
                    set_upd_en = 1'b1;
                    set_upd_wr = 1'b1;
                    vb_op      = VB_SWAP;
                end
            end
            ST_MISS_WAIT: begin
                if (mem_ack) begin
                    set_upd_en = 1'b1;
                    set_upd_wr = 1'b1;
                    vb_op      = VB_PUSH;
                end
            end
        endcase
    end

    // response register
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_lat   <= '0;
        end else begin
            resp_valid <= (accept && any_hit) || fill_now;
            resp_hit   <= accept && any_hit;
            resp_lat   <= (accept && any_hit) ? LAT_W'(1) : LAT_W'(MISS_LAT);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = (state_q == ST_LOOKUP);
        mem_req   = (state_q == ST_MISS_WAIT);
        mem_addr  = miss_addr_q;
    end

endmodule

// File: rtl/l1vc_top.sv
module l1vc_top import l1vc_pkg::*; #(
    parameter int ADDR_W   = 16,
    parameter int NUM_SETS = 2,
    parameter int VB_N     = 3,
    parameter int MISS_LAT = 20,
    parameter int LAT_W    = $clog2(MISS_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LAT_W-1:0]  resp_lat,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);
    localparam int IDX_W = $clog2(VB_N);

    logic [ADDR_W-1:0] lk_addr;
    logic              main_hit, main_hit_way, main_lru_way;
    logic              vic_valid;
    logic [ADDR_W-1:0] vic_addr;
    logic              vb_hit;
    logic [IDX_W-1:0]  vb_hit_idx;
    logic              set_upd_en, set_upd_way, set_upd_wr;
    vb_op_e            vb_op;

    l1vc_ctrl #(
        .ADDR_W(ADDR_W), .MISS_LAT(MISS_LAT), .LAT_W(LAT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .mem_ack      (mem_ack),
        .main_hit     (main_hit),
        .main_hit_way (main_hit_way),
        .main_lru_way (main_lru_way),
        .vb_hit       (vb_hit),
        .req_ready    (req_ready),
        .lk_addr      (lk_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .resp_lat     (resp_lat),
        .set_upd_en   (set_upd_en),
        .set_upd_way  (set_upd_way),
        .set_upd_wr   (set_upd_wr),
        .vb_op        (vb_op)
    );

    l1vc_sets #(
        .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS)
    ) u_sets (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (lk_addr),
        .upd_en    (set_upd_en),
        .upd_way   (set_upd_way),
        .upd_wr    (set_upd_wr),
        .hit       (main_hit),
        .hit_way   (main_hit_way),
        .lru_way   (main_lru_way),
        .vic_valid (vic_valid),
        .vic_addr  (vic_addr)
    );

    l1vc_vbuf #(
        .ADDR_W(ADDR_W), .VB_N(VB_N)
    ) u_vbuf (
        .clk      (clk),
        .rst      (rst),
        .lk_addr  (lk_addr),
        .op       (vb_op),
        .op_idx   (vb_hit_idx),
        .wr_valid (vic_valid),
        .wr_addr  (vic_addr),
        .hit      (vb_hit),
        .hit_idx  (vb_hit_idx)
    );

endmodule

// File: rtl/l1vc_chk.sv
module l1vc_chk #(
    parameter int ADDR_W   = 16,
    parameter int MISS_LAT = 20,
    parameter int LAT_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [LAT_W-1:0]  resp_lat,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              main_hit,
    input logic              vb_hit
);
    // R3
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3
    ack_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (resp_valid && !resp_hit));

    // R2
    accept_next_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ((resp_valid && resp_hit) || mem_req));

    // R2
    lat_class_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_lat == (resp_hit ? LAT_W'(1) : LAT_W'(MISS_LAT))));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R5
    no_dup_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_hit, vb_hit}));
endmodule

bind l1vc_top l1vc_chk #(
    .ADDR_W(ADDR_W), .MISS_LAT(MISS_LAT), .LAT_W(LAT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_lat   (resp_lat),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .main_hit   (main_hit),
    .vb_hit     (vb_hit)
);

// File: tb/tb_l1vc_top.sv
`timescale 1ns/1ps
module tb_l1vc_top;
    localparam int AW       = 16;
    localparam int MISS_LAT = 20;
    localparam int LW       = $clog2(MISS_LAT + 1);
    localparam int ACK_DLY  = 2;

    // {all_hit, loop length}
    localparam logic [5:0] LOOP_VEC [5] = '{6'h25, 6'h26, 6'h27, 6'h08, 6'h09};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          mem_ack = 1'b0;
    logic          req_ready, resp_valid, resp_hit, mem_req;
    logic [LW-1:0] resp_lat;
    logic [AW-1:0] mem_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int ack_cnt  = 0;
    int cyc_cnt  = 0;

    always #2 clk = ~clk;

    l1vc_top #(.ADDR_W(AW), .MISS_LAT(MISS_LAT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_lat(resp_lat), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack)
    );

    // next-level model: acknowledge after ACK_DLY request cycles
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            ack_cnt = 0;
        end else if (mem_req) begin
            ack_cnt++;
            if (ack_cnt >= ACK_DLY) mem_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic [AW-1:0] a, output logic hit,
                          output logic [LW-1:0] lat, output int cyc,
                          output logic [AW-1:0] seen_addr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        seen_addr = '1;
        while (!resp_valid && cyc < 200) begin
            if (mem_req) seen_addr = mem_addr;
            @(negedge clk);
            cyc++;
        end
        hit = resp_hit;
        lat = resp_lat;
    endtask

    // one access with expected hit/miss, including latency class and timing
    task automatic expect_access(input string req, input logic [AW-1:0] a, input logic exp_hit);
        logic h;
        logic [LW-1:0] l;
        int c;
        logic [AW-1:0] sa;
        access(a, h, l, c, sa);
        check(req, h, exp_hit);
        check(req, l, exp_hit ? 1 : MISS_LAT);
        if (exp_hit) check(req, c, 1);
        else         check(req, sa, a);
    endtask

    initial begin
        logic h;
        logic [LW-1:0] l;
        int c;
        logic [AW-1:0] sa;

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 req_ready", req_ready, 1);
        check("R1 resp_valid", resp_valid, 0);
        check("R1 mem_req", mem_req, 0);

        // R7: cyclic loops from the table
        for (int v = 0; v < 5; v++) begin
            int n = int'(LOOP_VEC[v][4:0]);
            logic all_hit = LOOP_VEC[v][5];
            do_reset();
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < n; k++) begin
                    access(AW'(k), h, l, c, sa);
                    if (p == 0 && k == 0) begin
                        check("R1 first access misses", h, 0);
                        check("R3 miss address", sa, k);
                        check("R3 miss latency class", l, MISS_LAT);
                    end
                    if (p == 3) begin
                        check($sformatf("R7 loop %0d steady hit", n), h, all_hit);
                        check($sformatf("R7 loop %0d latency", n), l, all_hit ? 1 : MISS_LAT);
                    end
                end
            end
        end

        // R4 R5 R6: recency in sets and victim buffer
        do_reset();
        expect_access("R4 fill 0", 0, 0);
        expect_access("R4 fill 2", 2, 0);
        expect_access("R2 main hit 0", 0, 1);
        expect_access("R4 fill 4 evicts 2", 4, 0);
        expect_access("R6 fill 6", 6, 0);
        expect_access("R6 fill 8", 8, 0);
        expect_access("R6 fill 10", 10, 0);
        expect_access("R5 victim hit 4", 4, 1);
        expect_access("R4 block 2 dropped", 2, 0);
        expect_access("R6 refreshed 8 kept", 8, 1);
        expect_access("R6 oldest 0 dropped", 0, 0);

        // R8: no prefetch of neighbour
        do_reset();
        expect_access("R8 fill 6", 6, 0);
        expect_access("R8 neighbour 7 misses", 7, 0);
        expect_access("R2 main hit 6", 6, 1);

        // R9: request while miss outstanding is ignored
        do_reset();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 12;
        @(negedge clk);
        req_addr  = 13;
        check("R9 req_ready low while busy", req_ready, 0);
        c = 0;
        while (!resp_valid && c < 200) begin
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        check("R9 response for first request", resp_hit, 0);
        @(negedge clk);
        check("R9 no extra response", resp_valid, 0);
        expect_access("R9 ignored address 13 misses", 13, 0);
        expect_access("R9 first address 12 hits", 12, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule